// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general purpose I/O controller for a pin count that is a multiple of 32, 64 by default and 96 as the other supported size. Software drives it through a plain 32-bit register bus. Each pin has an output latch and a direction bit. Two-flop synchronizers sample the pads, which can then be read back as levels.

Registers are grouped by function, and each function spans one 32-bit word per 32 pins. The output latch is never written directly. Software changes it with a write-ones-to-set word and a write-ones-to-clear word, so that two agents updating different pins need no read-modify-write. Each pin has its own rising-edge enable and falling-edge enable. A qualifying edge on a pin latches a sticky status bit, which software clears by writing a one to it. A registered interrupt line is high while any status bit is pending.

Top module: `pinbank_ctrl`

## Requirements
- R1: Let W = PINS/32. Function f, word w lives at byte address f*W*4 + w*4. The function codes are: 0 level, 1 direction, 2 output set, 3 output clear, 4 rising enable, 5 falling enable, 6 edge status. Pin p is bit p%32 of word p/32. An address at or above 7*W*4 reads as zero, and a write to it changes nothing.
- R2: After reset, pin_oe and pin_out are all zero, both edge enables are zero, status is zero and irq is low.
- R3: A direction bit of 1 drives that pin's pin_oe high, and 0 makes the pin an input. The direction word reads back as written.
- R4: A write to the set word drives pin_out high for each 1 bit. Each 0 bit leaves its pin unchanged. The set word reads as zero.
- R5: A write to the clear word drives pin_out low for each 1 bit. Each 0 bit leaves its pin unchanged. The clear word reads as zero.
- R6: The level word returns pin_in through a two-flop synchronizer, so a change is visible two clock edges after it is sampled. A write to the level word is ignored.
- R7: When a pin's rising enable is 1, a 0-to-1 change of its synchronized input sets its status bit.
- R8: When a pin's falling enable is 1, a 1-to-0 change sets its status bit. With both enables set, either edge sets the bit. With neither enable set, the pin never sets its bit.
- R9: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R10: If a qualifying edge arrives in the same cycle as a write that clears the pin's status bit, the bit stays set.
- R11: irq is a register that is high exactly while at least one status bit is set. It rises and falls on the same clock edge as the status change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | Byte address of the accessed word |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| pin_in | input | PINS | Pad input levels (asynchronous) |
| pin_out | output | PINS | Output latch values |
| pin_oe | output | PINS | Output enable per pin (1 = drive) |
| irq | output | 1 | Combined edge interrupt |

## Verification
The output latch is exercised with set and clear masks that overlap earlier writes, which separates a true OR/AND-NOT update from an overwrite. The edge logic is driven with single pins toggled under rising-only, falling-only, both and no enables, which separates the polarity of each enable and shows that a disabled pin stays silent. Pins in the upper word and an address past the map check the word and function arithmetic. A rising edge is placed in the exact cycle of a status-clear write, which separates an event-wins merge from a clear-wins merge.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
    localparam int unsigned REG_BITS = 32;
    localparam int unsigned FN_COUNT = 7;

    // Function order sets the address map
    typedef enum logic [2:0] {
        FN_LEVEL = 3'd0,
        FN_DIR   = 3'd1,
        FN_SET   = 3'd2,
        FN_CLR   = 3'd3,
        FN_RISE  = 3'd4,
        FN_FALL  = 3'd5,
        FN_STAT  = 3'd6
    } fn_e;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int unsigned PINS = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] lvl,
    output logic [PINS-1:0] rise,
    output logic [PINS-1:0] fall
);
    typedef struct packed {
        logic [PINS-1:0] s1;
        logic [PINS-1:0] s2;
        logic [PINS-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin_in;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl  = st_q.s2;
    assign rise = st_q.s2 & ~st_q.prev;
    assign fall = ~st_q.s2 & st_q.prev;

    AST_LEVEL_TWO_FLOP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ##1 (lvl == $past(pin_in, 2))); // R6
endmodule

// File: rtl/pinbank_decode.sv
module pinbank_decode
    import pinbank_pkg::*;
#(
    parameter int unsigned WORDS  = 2,
    parameter int unsigned ADDR_W = 6,
    localparam int unsigned PINS   = WORDS * REG_BITS,
    localparam int unsigned WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [REG_BITS-1:0] wdata,
    output logic                hit,
    output fn_e                 fn,
    output logic [WIDX_W-1:0]   word_idx,
    output logic [PINS-1:0]     wide_sel,
    output logic [PINS-1:0]     wide_data
);
    logic [31:0] idx32;

    assign idx32    = 32'(addr[ADDR_W-1:2]);
    assign hit      = idx32 < FN_COUNT * WORDS;
    assign fn       = fn_e'(3'(idx32 / WORDS));
    assign word_idx = WIDX_W'(idx32 % WORDS);

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic sel;
        assign sel = hit && (word_idx == WIDX_W'(w));
        assign wide_sel[w*REG_BITS +: REG_BITS]  = {REG_BITS{sel}};
        assign wide_data[w*REG_BITS +: REG_BITS] = sel ? wdata : '0;
    end

    always_comb begin
        assert ($countones({hit, wide_sel}) == 0 || hit); // R1 selection only on a hit
    end
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int unsigned  PINS   = 64,
    localparam int unsigned WORDS  = PINS / REG_BITS,
    localparam int unsigned ADDR_W = $clog2(FN_COUNT * WORDS * 4),
    localparam int unsigned WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [REG_BITS-1:0] bus_wdata,
    output logic [REG_BITS-1:0] bus_rdata,
    input  logic [PINS-1:0]     pin_in,
    output logic [PINS-1:0]     pin_out,
    output logic [PINS-1:0]     pin_oe,
    output logic                irq
);
    typedef struct packed {
        logic [PINS-1:0] out;
        logic [PINS-1:0] dir;
        logic [PINS-1:0] ren;
        logic [PINS-1:0] fen;
        logic [PINS-1:0] stat;
        logic            irq;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic              hit;
    fn_e               fn;
    logic [WIDX_W-1:0] word_idx;
    logic [PINS-1:0]   wide_sel, wide_data;
    logic [PINS-1:0]   lvl, rise, fall;
    logic [PINS-1:0]   set_mask, clr_mask, stat_clr, ev;

    pinbank_decode #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_decode (
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .hit       (hit),
        .fn        (fn),
        .word_idx  (word_idx),
        .wide_sel  (wide_sel),
        .wide_data (wide_data)
    );

    pinbank_sync #(.PINS(PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .lvl    (lvl),
        .rise   (rise),
        .fall   (fall)
    );

    assign set_mask = (bus_we && hit && fn == FN_SET)  ? wide_data : '0;
    assign clr_mask = (bus_we && hit && fn == FN_CLR)  ? wide_data : '0;
    assign stat_clr = (bus_we && hit && fn == FN_STAT) ? wide_data : '0;
    assign ev       = (rise & st_q.ren) | (fall & st_q.fen);

    always_comb begin
        st_d     = st_q;
        st_d.out = (st_q.out | set_mask) & ~clr_mask;
        if (bus_we && hit) begin
            case (fn)
                FN_DIR:  st_d.dir = (st_q.dir & ~wide_sel) | wide_data;
                FN_RISE: st_d.ren = (st_q.ren & ~wide_sel) | wide_data;
                FN_FALL: st_d.fen = (st_q.fen & ~wide_sel) | wide_data;
                default: ;
            endcase
        end
        // A fresh event outranks a clear in the same cycle
        st_d.stat = (st_q.stat & ~stat_clr) | ev;
        st_d.irq  = |st_d.stat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            case (fn)
                FN_LEVEL: bus_rdata = lvl[word_idx*REG_BITS +: REG_BITS];
                FN_DIR:   bus_rdata = st_q.dir[word_idx*REG_BITS +: REG_BITS];
                FN_RISE:  bus_rdata = st_q.ren[word_idx*REG_BITS +: REG_BITS];
                FN_FALL:  bus_rdata = st_q.fen[word_idx*REG_BITS +: REG_BITS];
                FN_STAT:  bus_rdata = st_q.stat[word_idx*REG_BITS +: REG_BITS];
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign pin_out = st_q.out;
    assign pin_oe  = st_q.dir;
    assign irq     = st_q.irq;

    AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0) |=> ((pin_out & $past(set_mask)) == $past(set_mask))); // R4
    AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((pin_out & $past(clr_mask)) == '0)); // R5
    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(st_q.stat) & ~st_q.stat) & ~$past(stat_clr)) == '0)); // R9
    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev & stat_clr) != '0) |=> ((st_q.stat & $past(ev & stat_clr)) == $past(ev & stat_clr))); // R10
    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(ev) != '0)); // R11
    AST_LEVEL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit && fn == FN_LEVEL) |=> ($stable(pin_out) && $stable(pin_oe))); // R6
    AST_MISS_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !hit) |=> ($stable(pin_oe) && $stable(pin_out))); // R1
endmodule

// File: tb/pinbank_ctrl_tb.sv
module pinbank_ctrl_tb_top;
    localparam int PINS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [PINS-1:0] pin_in = '0;
    logic [PINS-1:0] pin_out, pin_oe;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    pinbank_ctrl #(.PINS(PINS)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // byte address of function f, word w (two words per function)
    function automatic logic [5:0] ra(int f, int w);
        return 6'(f * 8 + w * 4);
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic drive_pin(int p, logic v);
        @(negedge clk);
        pin_in[p] = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R2 pin_oe", pin_oe, '0);
        chk("R2 pin_out", pin_out, '0);
        chk("R2 irq", {63'd0, irq}, 64'd0);
        rd(ra(6, 0), d); chk("R2 status", {32'd0, d}, 64'd0);
        rd(ra(4, 1), d); chk("R2 rise enable", {32'd0, d}, 64'd0);
    endtask

    task automatic t_dir();
        logic [31:0] d;
        wr(ra(1, 1), 32'h0000_0F00);
        chk("R3 R1 pin_oe upper word", pin_oe, 64'h0000_0F00_0000_0000);
        rd(ra(1, 1), d); chk("R3 readback", {32'd0, d}, 64'h0F00);
        wr(ra(1, 0), 32'h8000_0001);
        chk("R3 pin_oe both words", pin_oe, 64'h0000_0F00_8000_0001);
    endtask

    task automatic t_set_clr();
        logic [31:0] d;
        wr(ra(2, 0), 32'h5);
        chk("R4 set", pin_out, 64'h5);
        wr(ra(2, 0), 32'h2);
        chk("R4 zeros keep", pin_out, 64'h7);
        wr(ra(2, 1), 32'h1);
        chk("R4 R1 set pin 32", pin_out, 64'h1_0000_0007);
        rd(ra(2, 0), d); chk("R4 reads zero", {32'd0, d}, 64'd0);
        wr(ra(3, 0), 32'h1);
        chk("R5 clear", pin_out, 64'h1_0000_0006);
        rd(ra(3, 1), d); chk("R5 reads zero", {32'd0, d}, 64'd0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        @(negedge clk);
        pin_in = 64'hC3A5_0000_1234_A5A5;
        @(negedge clk);
        bus_addr = ra(0, 0);
        #1 chk("R6 not yet after one edge", {32'd0, bus_rdata}, 64'd0);
        @(negedge clk);
        #1 chk("R6 visible after two edges", {32'd0, bus_rdata}, 64'h1234_A5A5);
        rd(ra(0, 1), d); chk("R6 upper word", {32'd0, d}, 64'hC3A5_0000);
        wr(ra(0, 0), 32'hFFFF_FFFF);
        rd(ra(0, 0), d); chk("R6 write ignored", {32'd0, d}, 64'h1234_A5A5);
        chk("R6 write left outputs", pin_out, 64'h1_0000_0006);
        rd(ra(6, 0), d); chk("R8 no enable no status", {32'd0, d}, 64'd0);
        @(negedge clk);
        pin_in = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_range();
        logic [31:0] d;
        rd(6'd56, d); chk("R1 past map reads zero", {32'd0, d}, 64'd0);
        wr(6'd60, 32'hFFFF_FFFF);
        chk("R1 past map write ignored oe", pin_oe, 64'h0000_0F00_8000_0001);
        chk("R1 past map write ignored out", pin_out, 64'h1_0000_0006);
    endtask

    task automatic t_rise();
        logic [31:0] d;
        wr(ra(4, 1), 32'h100);           // pin 40 rising
        drive_pin(40, 1'b1);
        rd(ra(6, 1), d); chk("R7 rising sets", {32'd0, d}, 64'h100);
        chk("R11 irq high", {63'd0, irq}, 64'd1);
        wr(ra(6, 1), 32'h0);
        rd(ra(6, 1), d); chk("R9 zero write keeps", {32'd0, d}, 64'h100);
        drive_pin(40, 1'b0);
        rd(ra(6, 1), d); chk("R7 falling ignored", {32'd0, d}, 64'h100);
        wr(ra(6, 1), 32'h100);
        rd(ra(6, 1), d); chk("R9 one write clears", {32'd0, d}, 64'd0);
        chk("R11 irq low", {63'd0, irq}, 64'd0);
        wr(ra(4, 1), 32'h0);
    endtask

    task automatic t_fall_both();
        logic [31:0] d;
        wr(ra(5, 0), 32'h28);            // pins 3 and 5 falling
        wr(ra(4, 0), 32'h20);            // pin 5 rising too
        drive_pin(3, 1'b1);
        rd(ra(6, 0), d); chk("R8 falling-only ignores rise", {32'd0, d}, 64'd0);
        drive_pin(3, 1'b0);
        rd(ra(6, 0), d); chk("R8 falling sets", {32'd0, d}, 64'h8);
        wr(ra(6, 0), 32'h8);
        drive_pin(5, 1'b1);
        rd(ra(6, 0), d); chk("R8 both: rise", {32'd0, d}, 64'h20);
        wr(ra(6, 0), 32'h20);
        drive_pin(5, 1'b0);
        rd(ra(6, 0), d); chk("R8 both: fall", {32'd0, d}, 64'h20);
        wr(ra(6, 0), 32'h20);
        drive_pin(7, 1'b1);
        drive_pin(7, 1'b0);
        rd(ra(6, 0), d); chk("R8 disabled pin silent", {32'd0, d}, 64'd0);
        chk("R11 irq idle", {63'd0, irq}, 64'd0);
        wr(ra(4, 0), 32'h0);
        wr(ra(5, 0), 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] d;
        wr(ra(4, 0), 32'h400);           // pin 10 rising
        drive_pin(10, 1'b1);
        drive_pin(10, 1'b0);
        rd(ra(6, 0), d); chk("R7 pin 10 set", {32'd0, d}, 64'h400);
        // edge reaches the detector two edges after the change; clear lands on the same edge
        @(negedge clk);
        pin_in[10] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = ra(6, 0); bus_wdata = 32'h400; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        rd(ra(6, 0), d); chk("R10 edge beats clear", {32'd0, d}, 64'h400);
        chk("R11 irq kept", {63'd0, irq}, 64'd1);
        wr(ra(6, 0), 32'h400);
        rd(ra(6, 0), d); chk("R10 later clear works", {32'd0, d}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dir();
        t_set_clr();
        t_level();
        t_range();
        t_rise();
        t_fall_both();
        t_collision();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule